// File: doc/BRIEF.md
# Synchronous NOR Burst Read Sequencer

This block runs burst reads from an external NOR-style memory that works on a divided clock. It takes a start request together with a word address, a word count, a clock divide value, a data latency and a chip-enable pulse limit. It then drives the memory clock, the active-low chip enable, the active-low address-valid strobe and the address. It counts off the latency in memory clock cycles and then takes one data word on each rising memory clock edge. Each word is passed to the system side with a one-cycle valid strobe.

The memory clock comes from a phase counter that runs on the system clock. In every memory period the clock is low for the first floor(P/2) system cycles and high for the rest. P is the divide value plus one, and a divide value of 0 counts as 1. The phase counter starts together with the address-valid strobe. So the first cycle of an access never carries a clock edge, and the first rising edge falls inside the strobe's low pulse. Some memories cannot keep chip enable low for long. For them, the block caps the number of rising clock edges in one chip-enable pulse. When a burst reaches that cap, the block closes the pulse, keeps chip enable high for one memory period, and reopens the access at the next address with a new latency wait.

Top module: `nor_burst_reader`

## Requirements
- R1: During and after reset, with no access running: chip enable high, address-valid high, memory clock low, address bus zero, no valid strobe and no done flag.
- R2: While an access runs, rising memory clock edges are exactly P system cycles apart. P = div_i + 1, and div_i = 0 behaves as div_i = 1, giving P = 2.
- R3: Take t0 as the cycle in which start_i is seen. In cycle t0+1, chip enable and address-valid go low, the address is driven and the memory clock is low. Address-valid stays low for exactly P cycles, and the address bus carries the access address only while address-valid is low (zero otherwise). The first rising memory clock edge comes floor(P/2) cycles after address-valid goes low.
- R4: Count the rising edge inside the address-valid pulse as edge 0. The first word is taken on edge lat_i+1, and rd_valid_o first rises in cycle t0 + 2 + floor(P/2) + (lat_i+1)*P.
- R5: Each word is the value of mem_data_i at the end of the first high cycle of its memory clock edge. It is presented one cycle later on rd_data_o with a one-cycle rd_valid_o pulse. A burst returns len_i words from consecutive addresses (wrapping at the address width), and len_i = 0 returns one word.
- R6: One chip-enable low pulse holds at most max(cemax_i, lat_i+2) rising memory clock edges.
- R7: When the limit ends a pulse before the burst is complete, chip enable stays high for P cycles. A new pulse then starts with its own address-valid strobe on the next unread address and waits out the latency again.
- R8: P cycles after the edge that takes the final word, chip enable goes high and the memory clock stays low. In that same cycle, done_o is high for exactly one cycle.
- R9: A start_i pulse while a burst is running is ignored: no extra words, no extra done, and no new access after the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a burst (sampled while idle) |
| addr_i | input | ADDR_W | First word address of the burst |
| len_i | input | LEN_W | Words in the burst (0 means 1) |
| div_i | input | DIV_W | Clock divide value, period = div_i+1 (0 means 1) |
| lat_i | input | LAT_W | Memory clock edges to skip before the first word |
| cemax_i | input | CEM_W | Maximum rising edges per chip-enable pulse |
| mem_data_i | input | DATA_W | Read data from the memory |
| mem_clk_o | output | 1 | Divided memory clock |
| mem_ce_n_o | output | 1 | Active-low chip enable |
| mem_adv_n_o | output | 1 | Active-low address-valid strobe |
| mem_addr_o | output | ADDR_W | Address bus |
| rd_data_o | output | DATA_W | Captured read word |
| rd_valid_o | output | 1 | One-cycle strobe per captured word |
| done_o | output | 1 | One-cycle pulse when a burst ends |

## Verification
The bench runs bursts with even and odd clock periods, with the zero divide value, with zero and nonzero latency, and with an address that wraps. These separate a correct phase split and latency count from designs that are off by one period or one half-period. Pulse limits below the burst length force one or more reopened accesses. Comparing the addresses and words across each reopening shows whether the next address and the new latency wait are handled. A zero length, a limit below the latency floor and a start pulse during a busy burst cover the clamping and ignore rules.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } seq_state_e;

    // Memory clock period in system cycles; a zero divide acts as one.
    function automatic int unsigned clk_period(input int unsigned div);
        return ((div == 0) ? 1 : div) + 1;
    endfunction

    // Low part of each memory clock period (comes first in the period).
    function automatic int unsigned clk_low_len(input int unsigned per);
        return per / 2;
    endfunction

    // Edge budget per chip-enable pulse, never below latency + 2.
    function automatic int unsigned pulse_limit(input int unsigned cemax,
                                                input int unsigned lat);
        return (cemax > lat + 2) ? cemax : lat + 2;
    endfunction

endpackage

// File: rtl/nor_rd_phase.sv
module nor_rd_phase #(
    parameter int PH_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            run,
    input  logic [PH_W-1:0] per,
    input  logic [PH_W-1:0] lo,
    output logic            ph_hi,
    output logic            at_edge,
    output logic            at_last,
    output logic            at_prelo
);
    logic [PH_W-1:0] ph;

    assign at_last  = (ph == per - PH_W'(1));
    assign at_edge  = (ph == lo);
    assign at_prelo = (ph == lo - PH_W'(1));
    assign ph_hi    = (ph >= lo);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ph <= '0;
        end else if (run) begin
            ph <= at_last ? '0 : ph + PH_W'(1);
        end
    end

    // R2: phase never leaves one memory period while counting
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run |-> (ph < per));

endmodule

// File: rtl/nor_rd_capture.sv
module nor_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= sample;
            if (sample) rd_data_o <= mem_data_i;
        end
    end

    // R5: every word gets a single-cycle strobe
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |=> !rd_valid_o);

endmodule

// File: rtl/nor_rd_ctrl.sv
module nor_rd_ctrl
    import nor_rd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int DIV_W  = 4,
    parameter int LAT_W  = 4,
    parameter int CEM_W  = 8,
    parameter int PH_W   = DIV_W + 1,
    parameter int EC_W   = ((CEM_W > LAT_W + 1) ? CEM_W : LAT_W + 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [LAT_W-1:0]  lat_i,
    input  logic [CEM_W-1:0]  cemax_i,
    input  logic              ph_hi,
    input  logic              at_edge,
    input  logic              at_last,
    input  logic              at_prelo,
    output logic              ph_clear,
    output logic              ph_run,
    output logic [PH_W-1:0]   per,
    output logic [PH_W-1:0]   lo,
    output logic              sample,
    output logic              mem_clk_o,
    output logic              mem_ce_n_o,
    output logic              mem_adv_n_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              done_o
);
    typedef struct packed {
        logic [PH_W-1:0]  per;
        logic [PH_W-1:0]  lo;
        logic [LAT_W-1:0] lat;
        logic [EC_W-1:0]  lim;
    } seq_cfg_t;

    seq_state_e        state;
    seq_cfg_t          cfg, cfg_n;
    logic [ADDR_W-1:0] seg_addr, nxt_addr;
    logic [LEN_W-1:0]  rem;
    logic [EC_W-1:0]   edges;
    logic              adv_q, closing, done_q;
    logic              is_active, last_word, limit_hit, leave_active;

    always_comb begin
        cfg_n.per = PH_W'(clk_period(32'(div_i)));
        cfg_n.lo  = PH_W'(clk_low_len(clk_period(32'(div_i))));
        cfg_n.lat = lat_i;
        cfg_n.lim = EC_W'(pulse_limit(32'(cemax_i), 32'(lat_i)));
    end

    assign is_active    = (state == ST_ACTIVE);
    assign sample       = is_active && at_edge && !closing && (edges > EC_W'(cfg.lat));
    assign last_word    = (rem == LEN_W'(1));
    assign limit_hit    = (edges == cfg.lim - EC_W'(1));
    assign leave_active = is_active && closing && at_prelo;

    assign ph_clear = ((state == ST_IDLE) && start_i) || leave_active;
    assign ph_run   = (state != ST_IDLE);
    assign per      = cfg.per;
    assign lo       = cfg.lo;

    assign mem_clk_o   = is_active && ph_hi;
    assign mem_ce_n_o  = !is_active;
    assign mem_adv_n_o = !(is_active && adv_q);
    assign mem_addr_o  = (is_active && adv_q) ? seg_addr : '0;
    assign done_o      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg      <= '0;
            seg_addr <= '0;
            nxt_addr <= '0;
            rem      <= '0;
            edges    <= '0;
            adv_q    <= 1'b0;
            closing  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state    <= ST_ACTIVE;
                        cfg      <= cfg_n;
                        seg_addr <= addr_i;
                        nxt_addr <= addr_i;
                        rem      <= (len_i == '0) ? LEN_W'(1) : len_i;
                        edges    <= '0;
                        adv_q    <= 1'b1;
                        closing  <= 1'b0;
                    end
                end
                ST_ACTIVE: begin
                    if (at_edge && !closing) edges <= edges + EC_W'(1);
                    if (at_last) adv_q <= 1'b0;
                    if (sample) begin
                        nxt_addr <= nxt_addr + ADDR_W'(1);
                        rem      <= rem - LEN_W'(1);
                        if (last_word || limit_hit) closing <= 1'b1;
                    end
                    if (leave_active) begin
                        closing <= 1'b0;
                        if (rem == '0) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (at_last) begin
                        state    <= ST_ACTIVE;
                        seg_addr <= nxt_addr;
                        edges    <= '0;
                        adv_q    <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: the strobe only appears inside a chip-enable pulse
    p_adv_in_ce_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n_o |-> !mem_ce_n_o);

    // R3: opening cycle of every pulse has strobe low and no clock
    p_open_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ce_n_o) |-> (!mem_clk_o && !mem_adv_n_o));

    // R8: no memory clock outside a chip-enable pulse
    p_clk_off_idle_r8: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n_o |-> !mem_clk_o);

    // R8: done is a single pulse while chip enable is high
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (mem_ce_n_o && !mem_clk_o) ##1 !done_o);

    // R6: edge count inside one pulse stays within the budget
    p_edges_bounded_r6: assert property (@(posedge clk) disable iff (rst)
        is_active |-> (edges <= cfg.lim));

endmodule

// File: rtl/nor_burst_reader.sv
module nor_burst_reader #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8,
    parameter int DIV_W  = 4,
    parameter int LAT_W  = 4,
    parameter int CEM_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [LAT_W-1:0]  lat_i,
    input  logic [CEM_W-1:0]  cemax_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              mem_clk_o,
    output logic              mem_ce_n_o,
    output logic              mem_adv_n_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              done_o
);
    localparam int PH_W = DIV_W + 1;
    localparam int EC_W = ((CEM_W > LAT_W + 1) ? CEM_W : LAT_W + 1) + 1;

    logic            ph_hi, at_edge, at_last, at_prelo;
    logic            ph_clear, ph_run, sample;
    logic [PH_W-1:0] per, lo;

    nor_rd_phase #(.PH_W(PH_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .clear    (ph_clear),
        .run      (ph_run),
        .per      (per),
        .lo       (lo),
        .ph_hi    (ph_hi),
        .at_edge  (at_edge),
        .at_last  (at_last),
        .at_prelo (at_prelo)
    );

    nor_rd_ctrl #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DIV_W  (DIV_W),
        .LAT_W  (LAT_W),
        .CEM_W  (CEM_W),
        .PH_W   (PH_W),
        .EC_W   (EC_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .addr_i      (addr_i),
        .len_i       (len_i),
        .div_i       (div_i),
        .lat_i       (lat_i),
        .cemax_i     (cemax_i),
        .ph_hi       (ph_hi),
        .at_edge     (at_edge),
        .at_last     (at_last),
        .at_prelo    (at_prelo),
        .ph_clear    (ph_clear),
        .ph_run      (ph_run),
        .per         (per),
        .lo          (lo),
        .sample      (sample),
        .mem_clk_o   (mem_clk_o),
        .mem_ce_n_o  (mem_ce_n_o),
        .mem_adv_n_o (mem_adv_n_o),
        .mem_addr_o  (mem_addr_o),
        .done_o      (done_o)
    );

    nor_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .sample     (sample),
        .mem_data_i (mem_data_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

endmodule

// File: tb/nor_burst_reader_test.sv
module nor_burst_reader_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  len_i = '0;
    logic [3:0]  div_i = '0;
    logic [3:0]  lat_i = '0;
    logic [7:0]  cemax_i = '0;
    logic [15:0] mem_data_i = '0;
    logic        mem_clk_o, mem_ce_n_o, mem_adv_n_o, rd_valid_o, done_o;
    logic [15:0] mem_addr_o, rd_data_o;

    nor_burst_reader uut (
        .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
        .len_i(len_i), .div_i(div_i), .lat_i(lat_i), .cemax_i(cemax_i),
        .mem_data_i(mem_data_i), .mem_clk_o(mem_clk_o),
        .mem_ce_n_o(mem_ce_n_o), .mem_adv_n_o(mem_adv_n_o),
        .mem_addr_o(mem_addr_o), .rd_data_o(rd_data_o),
        .rd_valid_o(rd_valid_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int cur_p, cur_lo, cur_lat, cur_lim, start_t;
    int pres, got, done_cnt, edges_in_pulse;
    int adv_fall_t, last_rise_t, ce_rise_t, last_valid_t;
    bit gap_pending;
    logic [15:0] base_addr, lat_addr;
    logic [15:0] exp_q[$];
    logic prev_clk = 1'b0, prev_adv = 1'b1, prev_ce = 1'b1;

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return (a * 16'd13) ^ 16'hC35A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..: actual %0d expected %0d", cyc, 0);
            report();
            $finish;
        end
    end

    // Memory model and scoreboard monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_adv && !mem_adv_n_o) begin
                check(!mem_clk_o && !mem_ce_n_o, "R3", "open cycle clk/ce",
                      {mem_clk_o, mem_ce_n_o}, 0);
                check(mem_addr_o == base_addr + 16'(pres), "R7", "pulse address",
                      mem_addr_o, base_addr + 16'(pres));
                if (gap_pending)
                    check(cyc - ce_rise_t >= cur_p, "R7", "gap length",
                          cyc - ce_rise_t, cur_p);
                gap_pending = 0;
                adv_fall_t = cyc;
                edges_in_pulse = 0;
            end
            if (!prev_adv && mem_adv_n_o)
                check(cyc - adv_fall_t == cur_p, "R3", "adv low length",
                      cyc - adv_fall_t, cur_p);
            if (mem_adv_n_o)
                check(mem_addr_o == 16'h0, "R3", "address idle zero", mem_addr_o, 0);
            if (!prev_clk && mem_clk_o) begin
                if (edges_in_pulse == 0) begin
                    check(cyc - adv_fall_t == cur_lo && !mem_adv_n_o, "R3",
                          "first edge offset", cyc - adv_fall_t, cur_lo);
                    lat_addr = mem_addr_o;
                end else begin
                    check(cyc - last_rise_t == cur_p, "R2", "clock period",
                          cyc - last_rise_t, cur_p);
                end
                last_rise_t = cyc;
                if (edges_in_pulse >= cur_lat + 1) begin
                    mem_data_i = mem_word(lat_addr + 16'(edges_in_pulse - cur_lat - 1));
                    pres++;
                end else begin
                    mem_data_i = 16'h5A5A ^ 16'(cyc);
                end
                edges_in_pulse++;
                check(edges_in_pulse <= cur_lim, "R6", "edges per pulse",
                      edges_in_pulse, cur_lim);
            end else begin
                mem_data_i = 16'hA5A5 ^ 16'(cyc);
            end
            if (!prev_ce && mem_ce_n_o) begin
                ce_rise_t = cyc;
                if (!done_o) gap_pending = 1;
                check(cyc - last_rise_t == cur_p, "R8", "ce close after last edge",
                      cyc - last_rise_t, cur_p);
            end
            if (rd_valid_o) begin
                got++;
                if (exp_q.size() == 0) begin
                    check(0, "R5", "unexpected word", rd_data_o, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rd_data_o == e, "R5", "word value", rd_data_o, e);
                end
                if (got == 1)
                    check(cyc - start_t == 2 + cur_lo + (cur_lat + 1) * cur_p, "R4",
                          "first word latency", cyc - start_t,
                          2 + cur_lo + (cur_lat + 1) * cur_p);
                last_valid_t = cyc;
            end
            if (done_o) begin
                done_cnt++;
                check(mem_ce_n_o && !mem_clk_o, "R8", "done with ce high",
                      {mem_ce_n_o, mem_clk_o}, 2);
                check(cyc - last_valid_t == cur_p - 1, "R8", "done timing",
                      cyc - last_valid_t, cur_p - 1);
            end
            prev_clk = mem_clk_o;
            prev_adv = mem_adv_n_o;
            prev_ce  = mem_ce_n_o;
        end
    end

    task automatic run_burst(input logic [15:0] a, input int len, input int div,
                             input int lat, input int cemax, input bit poke);
        int n;
        bit stayed;
        cur_p   = ((div == 0) ? 1 : div) + 1;
        cur_lo  = cur_p / 2;
        cur_lat = lat;
        cur_lim = (cemax > lat + 2) ? cemax : lat + 2;
        n = (len == 0) ? 1 : len;
        base_addr = a;
        pres = 0; got = 0; done_cnt = 0; gap_pending = 0;
        for (int k = 0; k < n; k++) exp_q.push_back(mem_word(a + 16'(k)));
        @(negedge clk);
        addr_i = a; len_i = 8'(len); div_i = 4'(div); lat_i = 4'(lat);
        cemax_i = 8'(cemax); start_i = 1'b1;
        start_t = cyc;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R9: a second request mid-burst must be ignored
            repeat (cur_p * 2) @(negedge clk);
            addr_i = a + 16'h100; len_i = 8'd9; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        stayed = 1;
        for (int i = 0; i < cur_p * 4; i++) begin
            @(negedge clk);
            if (!mem_ce_n_o || rd_valid_o) stayed = 0;
        end
        check(exp_q.size() == 0, "R5", "words left unread", exp_q.size(), 0);
        check(got == n, "R5", "word count", got, n);
        check(done_cnt == 1 && stayed, "R9", "single done and idle after",
              done_cnt, 1);
        exp_q.delete();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(mem_ce_n_o && mem_adv_n_o && !mem_clk_o, "R1", "pins in reset",
              {mem_ce_n_o, mem_adv_n_o, mem_clk_o}, 6);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(mem_ce_n_o && mem_adv_n_o && !mem_clk_o && mem_addr_o == 0,
              "R1", "idle pins", {mem_ce_n_o, mem_adv_n_o, mem_clk_o}, 6);
        check(!rd_valid_o && !done_o, "R1", "idle flags", {rd_valid_o, done_o}, 0);

        run_burst(16'd100, 4, 1, 2, 50, 0);     // R2 R4 R5: P=2
        run_burst(16'd7, 3, 0, 0, 50, 0);       // R2: div 0 acts as 1
        run_burst(16'd300, 5, 3, 3, 100, 0);    // R3: P=4, lo=2
        run_burst(16'd40, 6, 4, 1, 5, 0);       // R6 R7: odd P, two pulses
        run_burst(16'd500, 3, 2, 2, 0, 0);      // R6: limit clamped to lat+2
        run_burst(16'd900, 0, 2, 1, 20, 0);     // R5: zero length gives one word
        run_burst(16'hFFFE, 4, 1, 1, 30, 1);    // R5 wrap, R9 start while busy
        run_burst(16'd12, 7, 5, 0, 3, 0);       // R7: many reopened pulses

        report();
        $finish;
    end
endmodule